// File: doc/BRIEF.md
# Per-Hart Software Interrupt Bank

This block is a small register bank that lets one hart raise a software interrupt on another hart. Each hart owns one 32-bit word in the bank's address window, and bit 0 of that word drives the hart's bit of the interrupt output vector. Software on any hart posts an inter-processor interrupt by writing to the target hart's word.

An elaboration parameter picks one of two behaviours. In machine mode each word holds a pending flag: writing 1 sets it, writing 0 clears it, and reading returns it. In supervisor mode a write of 1 only fires a single-cycle pulse on the hart's output, which the hart latches into its own pending state. Writes of 0 do nothing in this mode, and every read returns zero.

The bus side is a simple request port with a write enable, byte enables and a read path that has one cycle of latency. Only full 32-bit accesses to word-aligned, in-range offsets take effect.

Top module: `swi_bank`

## Requirements
- R1: While rst_ni is low, and right after it rises, every bit of irq_o is 0 and every machine-mode pending flag reads 0.
- R2: A write whose data has bit 0 set, to offset 4*n with n below NUM_HARTS, sets irq_o[n] from the clock edge that accepts the write. In machine mode the output then stays high.
- R3: In machine mode, a write to hart n's word with bit 0 clear drops irq_o[n] from the accepting edge.
- R4: In machine mode, a read of hart n's word returns that hart's pending flag in bit 0, with bits 31:1 zero. rdata_o carries the value in the cycle after the request edge and is zero in cycles with no accepted read.
- R5: In supervisor mode, a write of 1 to hart n's word drives irq_o[n] high for exactly the one cycle after the accepting edge.
- R6: In supervisor mode, a write of 0 leaves irq_o unchanged at zero, and every read returns zero.
- R7: Offsets at or above NUM_HARTS*4 are not decoded: writes there change no output, and reads there return zero.
- R8: An offset with bits 1:0 not equal to 00 is ignored: writes change nothing, and reads return zero.
- R9: An access whose be_i is not 4'hF is ignored: writes change nothing, and reads return zero.
- R10: Write-data bits 31:1 have no effect. Only bit 0 decides between setting and clearing.
- R11: A write changes only the addressed hart's output, and at most one hart is selected per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset in the bank window |
| be_i | input | 4 | Byte enables, must be 4'hF for an access to take effect |
| wdata_i | input | 32 | Write data, bit 0 significant |
| rdata_o | output | 32 | Read data, one cycle after the request |
| irq_o | output | NUM_HARTS | Software interrupt, one bit per hart |

## Verification
The bench drives one bus into a machine-mode instance and a supervisor-mode instance, so the two responses to each access can be compared side by side. Writes of 1, of 0, and of words whose upper bits are set but whose bit 0 is clear show whether bit 0 alone chooses between set and clear, and whether a zero write is a clear or a no-op. Misaligned, out-of-range and partial-byte accesses each show whether the matching decode term alone can block the access. Back-to-back writes of 1 to another hart and a reset in the middle of the run show that a pulse stays one cycle long and that held flags are dropped.

// File: rtl/swi_pkg.sv
package swi_pkg;
  typedef enum logic {
    SWI_MODE_MACH = 1'b0,  // held pending flag
    SWI_MODE_SUPV = 1'b1   // write-one pulse, reads zero
  } swi_mode_e;

  localparam int unsigned SWI_DATA_W = 32;
  localparam int unsigned SWI_BE_W   = SWI_DATA_W / 8;
endpackage

// File: rtl/swi_decode.sv
module swi_decode #(
  parameter int unsigned NUM_HARTS = 4,
  parameter int unsigned ADDR_W    = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [swi_pkg::SWI_BE_W-1:0] be_i,
  output logic [NUM_HARTS-1:0]       sel_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             acc_ok;

  assign idx    = addr_i[ADDR_W-1:2];
  assign acc_ok = req_i && (be_i == '1) && (addr_i[1:0] == 2'b00)
                  && ({1'b0, idx} < (IDX_W+1)'(NUM_HARTS));

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_sel
    assign sel_o[h] = acc_ok && (idx == IDX_W'(h));
  end

  // R11
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));

  // R8
  sel_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|sel_o) |-> (addr_i[1:0] == 2'b00));

  // R9
  sel_full_be_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|sel_o) |-> (be_i == 4'hF));
endmodule

// File: rtl/swi_slot.sv
module swi_slot #(
  parameter swi_pkg::swi_mode_e MODE = swi_pkg::SWI_MODE_MACH
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_i,
  input  logic [swi_pkg::SWI_DATA_W-1:0] wdata_i,
  output logic                          irq_o,
  output logic                          pend_o
);
  localparam int unsigned DW = swi_pkg::SWI_DATA_W;

  logic irq_q;

  if (MODE == swi_pkg::SWI_MODE_MACH) begin : g_mach
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   irq_q <= 1'b0;
      else if (wr_i) irq_q <= wdata_i[0];
    end
    assign pend_o = irq_q;

    // R3
    pend_chg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(irq_q) |-> $past(wr_i));

    // R10
    hi_bits_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !wdata_i[0] && (wdata_i[DW-1:1] != '0)) |=> !irq_q);
  end else begin : g_supv
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q <= 1'b0;
      else         irq_q <= wr_i && wdata_i[0];
    end
    assign pend_o = 1'b0;

    // R5
    pulse_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_q |-> $past(wr_i && wdata_i[0]));

    // R10
    hi_bits_nop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !wdata_i[0] && (wdata_i[DW-1:1] != '0)) |=> !irq_q);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/swi_rdata.sv
module swi_rdata #(
  parameter int unsigned NUM_HARTS = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           rd_i,
  input  logic [NUM_HARTS-1:0]           sel_i,
  input  logic [NUM_HARTS-1:0]           pend_i,
  output logic [swi_pkg::SWI_DATA_W-1:0] rdata_o
);
  logic [swi_pkg::SWI_DATA_W-1:0] rdata_q;
  logic                           bit_d;

  assign bit_d = rd_i && (|(sel_i & pend_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= {{(swi_pkg::SWI_DATA_W-1){1'b0}}, bit_d};
  end

  assign rdata_o = rdata_q;

  // R4
  rd_idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> (rdata_q == '0));
endmodule

// File: rtl/swi_bank.sv
module swi_bank #(
  parameter int unsigned        NUM_HARTS = 4,
  parameter int unsigned        ADDR_W    = 6,
  parameter swi_pkg::swi_mode_e MODE      = swi_pkg::SWI_MODE_MACH
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [3:0]           be_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  output logic [NUM_HARTS-1:0] irq_o
);
  logic [NUM_HARTS-1:0] sel;
  logic [NUM_HARTS-1:0] pend;
  logic                 rd;

  swi_decode #(.NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W)) u_decode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .addr_i (addr_i),
    .be_i   (be_i),
    .sel_o  (sel)
  );

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_slot
    swi_slot #(.MODE(MODE)) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (sel[h] && we_i),
      .wdata_i (wdata_i),
      .irq_o   (irq_o[h]),
      .pend_o  (pend[h])
    );
  end

  assign rd = (|sel) && !we_i;

  swi_rdata #(.NUM_HARTS(NUM_HARTS)) u_rdata (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (rd),
    .sel_i   (sel),
    .pend_i  (pend),
    .rdata_o (rdata_o)
  );

  // R4
  rd_hi_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[31:1] == '0);

  if (MODE == swi_pkg::SWI_MODE_SUPV) begin : g_supv_chk
    // R6
    supv_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rdata_o == '0);
  end
endmodule

// File: tb/swi_bank_tb.sv
module swi_bank_tb;
  localparam int unsigned NH = 4;
  localparam int unsigned AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [3:0]    be = 4'hF;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata_m, rdata_s;
  logic [NH-1:0] irq_m, irq_s;

  int checks = 0, errors = 0;
  logic [NH-1:0] model = '0;
  logic [31:0]   exp_m_q[$], exp_s_q[$];
  string         tag_q[$];
  logic          rd_seen;

  always #2 clk = ~clk;

  swi_bank #(.NUM_HARTS(NH), .ADDR_W(AW), .MODE(swi_pkg::SWI_MODE_MACH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .be_i(be), .wdata_i(wdata), .rdata_o(rdata_m), .irq_o(irq_m));

  swi_bank #(.NUM_HARTS(NH), .ADDR_W(AW), .MODE(swi_pkg::SWI_MODE_SUPV)) u_dut_s (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .be_i(be), .wdata_i(wdata), .rdata_o(rdata_s), .irq_o(irq_s));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic hit(logic [AW-1:0] a, logic [3:0] b);
    return (b == 4'hF) && (a[1:0] == 2'b00) && (a < AW'(NH*4));
  endfunction

  // monitor: pops expected read data after each accepted read edge
  always @(posedge clk) begin
    rd_seen = rst_n && req && !we;
    #1;
    if (rd_seen && exp_m_q.size() > 0) begin
      chk({tag_q.pop_front(), " mach read"}, rdata_m, exp_m_q.pop_front());
      chk("R6 supv read", rdata_s, exp_s_q.pop_front());
    end else if (rst_n) begin
      chk("R4 idle read data", rdata_m, 32'h0);
    end
  end

  // driver: one access, returns at the negedge after the accepting edge
  task automatic bus_op(logic w, logic [AW-1:0] a, logic [31:0] d,
                        logic [3:0] b, string tag);
    logic [NH-1:0] pulse;
    pulse = '0;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; be = b;
    if (!w) begin
      exp_m_q.push_back(hit(a, b) ? {31'h0, model[a[AW-1:2]]} : 32'h0);
      exp_s_q.push_back(32'h0);
      tag_q.push_back(tag);
    end else if (hit(a, b)) begin
      model[a[AW-1:2]] = d[0];
      if (d[0]) pulse[a[AW-1:2]] = 1'b1;
    end
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    if (w) begin
      chk({tag, " mach irq"}, 32'(irq_m), 32'(model));
      chk({tag, " supv irq"}, 32'(irq_s), 32'(pulse));
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R5 pulse ends", 32'(irq_s), 32'h0);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", 32'(irq_m | irq_s), 32'h0);
    rst_n = 1'b1;
    idle(1);
    bus_op(1'b0, 6'd0, '0, 4'hF, "R1");
    // R2 / R5: set hart 2
    bus_op(1'b1, 6'd8, 32'h1, 4'hF, "R2 R5 set hart2");
    idle(1);
    bus_op(1'b0, 6'd8, '0, 4'hF, "R4 hart2");
    bus_op(1'b0, 6'd4, '0, 4'hF, "R4 hart1");
    // R3 + R10: bit0 clear with upper bits set clears; supervisor ignores
    bus_op(1'b1, 6'd8, 32'hFFFF_FFFE, 4'hF, "R3 R10 R6 clear hart2");
    idle(1);
    bus_op(1'b1, 6'd0, 32'hA5A5_0001, 4'hF, "R10 set hart0");
    idle(1);
    bus_op(1'b1, 6'd12, 32'h1, 4'hF, "R2 set hart3");
    idle(1);
    // R7 out of range
    bus_op(1'b1, 6'd16, 32'h1, 4'hF, "R7 write oor");
    bus_op(1'b1, 6'd60, 32'h0, 4'hF, "R7 write oor zero");
    bus_op(1'b0, 6'd16, '0, 4'hF, "R7 read oor");
    // R8 misaligned
    bus_op(1'b1, 6'd5, 32'h1, 4'hF, "R8 write misaligned");
    bus_op(1'b1, 6'd2, 32'h0, 4'hF, "R8 clear misaligned");
    bus_op(1'b0, 6'd13, '0, 4'hF, "R8 read misaligned");
    // R9 partial byte enables
    bus_op(1'b1, 6'd0, 32'h0, 4'h3, "R9 partial clear");
    bus_op(1'b1, 6'd4, 32'h1, 4'h1, "R9 partial set");
    bus_op(1'b0, 6'd0, '0, 4'h7, "R9 partial read");
    bus_op(1'b0, 6'd0, '0, 4'hF, "R9 hart0 kept");
    // R11 only the addressed hart
    bus_op(1'b1, 6'd12, 32'h0, 4'hF, "R11 clear hart3");
    bus_op(1'b0, 6'd0, '0, 4'hF, "R11 hart0 intact");
    // R5 back-to-back writes keep pulsing, then drop
    bus_op(1'b1, 6'd4, 32'h1, 4'hF, "R5 b2b first");
    bus_op(1'b1, 6'd4, 32'h1, 4'hF, "R5 b2b second");
    idle(2);
    // R6 supervisor zero write
    bus_op(1'b1, 6'd4, 32'h0, 4'hF, "R6 zero write");
    idle(1);
    bus_op(1'b1, 6'd8, 32'h1, 4'hF, "R2 set hart2 again");
    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    model = '0;
    #1;
    chk("R1 irq cleared by reset", 32'(irq_m | irq_s), 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    bus_op(1'b0, 6'd8, '0, 4'hF, "R1 flag after reset");
    bus_op(1'b0, 6'd0, '0, 4'hF, "R1 hart0 after reset");
    idle(2);
    finish_run();
  end
endmodule